// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This peripheral guards a system against software that has stopped running. It counts down from a programmable initial value, one step per tick, where a tick comes from a parameterized divider on the system clock. The first time the count runs out, the block sets a sticky timeout flag and can raise an interrupt. This gives software a chance to recover. If the count runs out again while that flag is still set, the block latches a second-timeout flag and requests a system reset.

Software controls the block through a 16-bit register port with byte addresses. Through it, software can:
- restart the countdown;
- halt or enable the timer;
- read the remaining count;
- clear sticky flags by writing 1 to them;
- suppress the reset request with a no-reboot control.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset, the control register at 0x08 reads 0x0800 (halted). The count reads the default initial value, the status registers and the config register at 0x0C read 0, and both `irq_o` and `sys_rst_req_o` are low.
- R2: While the timer runs, the count falls by one every TICK_DIV clocks, counted from the reload or enable write. While halted, the count does not change.
- R3: A write to 0x00 with bit 0 set loads the count from the initial value and restarts the tick divider. Reading 0x00 returns the count in bits 9:0, with the upper bits zero.
- R4: The initial value is held in bits 9:0 of the register at 0x12. Writes never change bits 15:10, which read 0.
- R5: An initial-value write whose bits 9:0 are 0 to 3 is ignored entirely, and the register keeps its previous value.
- R6: Bit 11 of 0x08 halts the timer when it is 1. All 16 bits of 0x08 read back exactly as written.
- R7: A tick that arrives while the count is 0 is an expiry. An expiry reloads the count from the initial value. If bit 3 of 0x04 (the first-timeout flag) is clear, the expiry sets it.
- R8: An expiry while bit 3 of 0x04 is already set does three things: it sets bit 1 of 0x06 (second timeout), it sets bit 2 of 0x06 (boot flag), and it raises `sys_rst_req_o`. Clearing bit 3 before the next expiry restarts the two-stage sequence.
- R9: Writing 1 to bit 3 of 0x04, or to bit 1 or bit 2 of 0x06, clears that flag. Writing 0 leaves it unchanged.
- R10: Bit 4 of 0x0C (no-reboot) forces `sys_rst_req_o` low while it is set. All 16 bits of 0x0C read back exactly as written.
- R11: `irq_o` is high exactly when bit 3 of 0x04 and bit 13 of 0x0C (interrupt enable) are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Interrupt request after the first expiry |
| sys_rst_req_o | output | 1 | Reset request after the second expiry |

## Verification
A wrong count or a drifting tick divider becomes visible at the next read of 0x00. It also shifts the cycle in which the timeout flag appears, so an error shows within one tick period. A flag state that went wrong shows at once on `irq_o` or `sys_rst_req_o`, or at the next status read. A mishandled write filter shows as a wrong readback at 0x12, and later as an expiry period of the wrong length.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int REG_W = 16;
   localparam int ADR_W = 5;

   localparam logic [ADR_W-1:0] OFS_RELOAD = 5'h00;
   localparam logic [ADR_W-1:0] OFS_STS1   = 5'h04;
   localparam logic [ADR_W-1:0] OFS_STS2   = 5'h06;
   localparam logic [ADR_W-1:0] OFS_CTRL   = 5'h08;
   localparam logic [ADR_W-1:0] OFS_CFG    = 5'h0C;
   localparam logic [ADR_W-1:0] OFS_INIT   = 5'h12;

   localparam int BIT_HALT     = 11;
   localparam int BIT_FIRST    = 3;
   localparam int BIT_SECOND   = 1;
   localparam int BIT_BOOT     = 2;
   localparam int BIT_NOREBOOT = 4;
   localparam int BIT_IRQEN    = 13;

   typedef struct packed {
      logic first;
      logic second;
      logic boot;
   } wdt_flags_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
   parameter int TICK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic tick
);
   generate
      if (TICK_DIV == 1) begin : g_direct
         assign tick = run && !restart;
      end else begin : g_div
         localparam int W = $clog2(TICK_DIV);
         localparam logic [W-1:0] LAST = W'(TICK_DIV - 1);
         logic [W-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          cnt <= '0;
            else if (!run || restart || cnt == LAST) cnt <= '0;
            else                                 cnt <= cnt + 1'b1;
         end

         assign tick = run && !restart && (cnt == LAST);
      end
   endgenerate
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
   parameter int CNT_W        = 10,
   parameter int INIT_DEFAULT = 30
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             reload,
   input  logic [CNT_W-1:0] init_val,
   output logic [CNT_W-1:0] count,
   output logic             expire
);
   assign expire = tick && !reload && (count == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              count <= CNT_W'(INIT_DEFAULT);
      else if (reload)         count <= init_val;
      else if (tick) begin
         if (count == '0)      count <= init_val;
         else                  count <= count - 1'b1;
      end
   end
endmodule

// File: rtl/wdt_status.sv
module wdt_status
   import wdt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       expire,
   input  logic       clr_first,
   input  logic       clr_second,
   input  logic       clr_boot,
   output wdt_flags_t flags
);
   logic stage2;
   assign stage2 = expire && flags.first;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
      end else begin
         flags.first  <= (flags.first && !clr_first) || (expire && !flags.first);
         flags.second <= stage2 || (flags.second && !clr_second);
         flags.boot   <= stage2 || (flags.boot && !clr_boot);
      end
   end
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
   import wdt_pkg::*;
#(
   parameter int CNT_W        = 10,
   parameter int TICK_DIV     = 120_000_000,
   parameter int INIT_DEFAULT = 30,
   parameter int MIN_INIT     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ADR_W-1:0] bus_addr,
   input  logic             bus_wr,
   input  logic [REG_W-1:0] bus_wdata,
   output logic [REG_W-1:0] bus_rdata,
   output logic             irq_o,
   output logic             sys_rst_req_o
);
   localparam int PAD_W = REG_W - CNT_W;

   generate
      if (CNT_W < 3 || CNT_W > REG_W) begin : g_bad_width
         $error("CNT_W out of range");
      end
      if (INIT_DEFAULT < MIN_INIT || INIT_DEFAULT >= (1 << CNT_W)) begin : g_bad_init
         $error("INIT_DEFAULT out of range");
      end
      if (TICK_DIV < 1) begin : g_bad_div
         $error("TICK_DIV must be at least 1");
      end
   endgenerate

   logic [REG_W-1:0] ctrl_q, cfg_q, init_q;
   logic [CNT_W-1:0] count, init_val;
   logic             halt, reload_wr, tick, expire;
   logic             no_reboot, irq_en, init_ok;
   logic             first_flag, second_flag, boot_flag;
   wdt_flags_t       flags;

   assign init_val  = init_q[CNT_W-1:0];
   assign halt      = ctrl_q[BIT_HALT];
   assign no_reboot = cfg_q[BIT_NOREBOOT];
   assign irq_en    = cfg_q[BIT_IRQEN];
   assign reload_wr = bus_wr && (bus_addr == OFS_RELOAD) && bus_wdata[0];
   assign init_ok   = bus_wdata[CNT_W-1:0] >= CNT_W'(MIN_INIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= REG_W'(1) << BIT_HALT;
         cfg_q  <= '0;
         init_q <= REG_W'(INIT_DEFAULT);
      end else if (bus_wr) begin
         if (bus_addr == OFS_CTRL) ctrl_q <= bus_wdata;
         if (bus_addr == OFS_CFG)  cfg_q  <= bus_wdata;
         if (bus_addr == OFS_INIT && init_ok)
            init_q[CNT_W-1:0] <= bus_wdata[CNT_W-1:0];
      end
   end

   wdt_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
      .clk(clk), .rst_n(rst_n), .run(!halt), .restart(reload_wr), .tick(tick)
   );

   wdt_countdown #(.CNT_W(CNT_W), .INIT_DEFAULT(INIT_DEFAULT)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .reload(reload_wr),
      .init_val(init_val), .count(count), .expire(expire)
   );

   wdt_status u_sts (
      .clk(clk), .rst_n(rst_n), .expire(expire),
      .clr_first (bus_wr && bus_addr == OFS_STS1 && bus_wdata[BIT_FIRST]),
      .clr_second(bus_wr && bus_addr == OFS_STS2 && bus_wdata[BIT_SECOND]),
      .clr_boot  (bus_wr && bus_addr == OFS_STS2 && bus_wdata[BIT_BOOT]),
      .flags(flags)
   );

   assign first_flag  = flags.first;
   assign second_flag = flags.second;
   assign boot_flag   = flags.boot;

   assign irq_o         = first_flag && irq_en;
   assign sys_rst_req_o = second_flag && !no_reboot;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         OFS_RELOAD: bus_rdata = {{PAD_W{1'b0}}, count};
         OFS_STS1:   bus_rdata[BIT_FIRST] = first_flag;
         OFS_STS2: begin
            bus_rdata[BIT_SECOND] = second_flag;
            bus_rdata[BIT_BOOT]   = boot_flag;
         end
         OFS_CTRL:   bus_rdata = ctrl_q;
         OFS_CFG:    bus_rdata = cfg_q;
         OFS_INIT:   bus_rdata = init_q;
         default:    bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
   parameter int CNT_W    = 10,
   parameter int MIN_INIT = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] init_val,
   input logic             tick,
   input logic             expire,
   input logic             reload_wr,
   input logic             halt,
   input logic             first_flag,
   input logic             second_flag,
   input logic             no_reboot,
   input logic             irq_en,
   input logic             irq_o,
   input logic             sys_rst_req_o
);
   AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !reload_wr) |=> $stable(count)); // R6
   AST_DEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !reload_wr && count != '0) |=> (count == $past(count) - 1'b1)); // R2
   AST_FIRST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(first_flag) |-> $past(expire)); // R7
   AST_SECOND_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(second_flag) |-> ($past(expire) && $past(first_flag))); // R8
   AST_NO_REBOOT: assert property (@(posedge clk) disable iff (!rst_n)
      no_reboot |-> !sys_rst_req_o); // R10
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (irq_en && first_flag)); // R11
   AST_INIT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      init_val >= CNT_W'(MIN_INIT)); // R5
endmodule

bind wdt_two_stage wdt_checker #(.CNT_W(CNT_W), .MIN_INIT(MIN_INIT)) u_chk (
   .clk(clk), .rst_n(rst_n), .count(count), .init_val(init_val), .tick(tick),
   .expire(expire), .reload_wr(reload_wr), .halt(halt), .first_flag(first_flag),
   .second_flag(second_flag), .no_reboot(no_reboot), .irq_en(irq_en),
   .irq_o(irq_o), .sys_rst_req_o(sys_rst_req_o)
);

// File: tb/tb_wdt_two_stage.sv
`timescale 1ns/1ps
module tb_wdt_two_stage;
   localparam int D    = 3;
   localparam int INIT = 30;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq_o, sys_rst_req_o;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   wdt_two_stage #(.CNT_W(10), .TICK_DIV(D), .INIT_DEFAULT(INIT), .MIN_INIT(4)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
      .sys_rst_req_o(sys_rst_req_o)
   );

   // reference model built from the requirements
   logic [9:0]  m_cnt;
   int          m_presc;
   logic        m_first, m_second, m_boot;
   logic [15:0] m_ctrl, m_cfg, m_init;

   always @(posedge clk) begin : model
      logic run, reld, tk, ex, c1, c2, cb;
      if (!rst_n) begin
         m_cnt <= 10'(INIT); m_presc <= 0;
         m_first <= 0; m_second <= 0; m_boot <= 0;
         m_ctrl <= 16'h0800; m_cfg <= 16'h0; m_init <= 16'(INIT);
      end else begin
         run  = !m_ctrl[11];
         reld = bus_wr && bus_addr == 5'h00 && bus_wdata[0];
         tk   = run && !reld && m_presc == D - 1;
         ex   = tk && m_cnt == 0;
         m_presc <= (!run || reld || m_presc == D - 1) ? 0 : m_presc + 1;
         if (reld)    m_cnt <= m_init[9:0];
         else if (tk) m_cnt <= (m_cnt == 0) ? m_init[9:0] : m_cnt - 1'b1;
         c1 = bus_wr && bus_addr == 5'h04 && bus_wdata[3];
         c2 = bus_wr && bus_addr == 5'h06 && bus_wdata[1];
         cb = bus_wr && bus_addr == 5'h06 && bus_wdata[2];
         m_first  <= (m_first && !c1) || (ex && !m_first);
         m_second <= (ex && m_first) || (m_second && !c2);
         m_boot   <= (ex && m_first) || (m_boot && !cb);
         if (bus_wr && bus_addr == 5'h08) m_ctrl <= bus_wdata;
         if (bus_wr && bus_addr == 5'h0C) m_cfg <= bus_wdata;
         if (bus_wr && bus_addr == 5'h12 && bus_wdata[9:0] >= 10'd4) m_init[9:0] <= bus_wdata[9:0];
      end
   end

   function automatic logic [15:0] exp_rd(logic [4:0] a);
      case (a)
         5'h00:   return {6'b0, m_cnt};
         5'h04:   return {12'b0, m_first, 3'b0};
         5'h06:   return {13'b0, m_boot, m_second, 1'b0};
         5'h08:   return m_ctrl;
         5'h0C:   return m_cfg;
         5'h12:   return m_init;
         default: return 16'h0;
      endcase
   endfunction

   task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [4:0] a, logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_is(logic [4:0] a, logic [15:0] exp, string tag);
      bus_addr = a; #1;
      chk(tag, bus_rdata, exp);
   endtask

   task automatic rd_model(logic [4:0] a, string tag);
      bus_addr = a; #1;
      chk(tag, bus_rdata, exp_rd(a));
      chk("R11 irq_o vs model", 16'(irq_o), 16'(m_first && m_cfg[13]));
      chk("R8 R10 sys_rst_req_o vs model", 16'(sys_rst_req_o), 16'(m_second && !m_cfg[4]));
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : stim
      logic [15:0] held;
      void'($urandom(32'd20240607));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd_is(5'h08, 16'h0800, "R1 ctrl reset");
      rd_is(5'h00, 16'(INIT), "R1 count reset");
      rd_is(5'h04, 16'h0, "R1 sts1 reset");
      rd_is(5'h06, 16'h0, "R1 sts2 reset");
      rd_is(5'h0C, 16'h0, "R1 cfg reset");
      chk("R1 outputs low", {14'b0, irq_o, sys_rst_req_o}, 16'h0);
      // R4 R5 initial value register
      wr(5'h12, 16'hFC05);  rd_is(5'h12, 16'h0005, "R4 upper bits kept");
      wr(5'h12, 16'h0003);  rd_is(5'h12, 16'h0005, "R5 value 3 ignored");
      wr(5'h12, 16'h0400);  rd_is(5'h12, 16'h0005, "R5 value 0 ignored");
      // R3 reload while halted, R6 frozen
      wr(5'h00, 16'h0001);  rd_is(5'h00, 16'h0005, "R3 reload");
      idle(20);             rd_is(5'h00, 16'h0005, "R6 halted count frozen");
      wr(5'h08, 16'hA5A5);  rd_is(5'h08, 16'hA5A5, "R6 ctrl readback");
      // R2 tick spacing
      wr(5'h00, 16'h0001);
      idle(2);              rd_is(5'h00, 16'h0005, "R2 no tick before TICK_DIV");
      idle(1);              rd_is(5'h00, 16'h0004, "R2 tick at TICK_DIV");
      // R7 first expiry
      idle(14);             rd_is(5'h04, 16'h0000, "R7 no flag at count 0");
      rd_is(5'h00, 16'h0000, "R7 count reached 0");
      idle(1);              rd_is(5'h04, 16'h0008, "R7 first flag set");
      rd_is(5'h00, 16'h0005, "R7 reloaded on expiry");
      chk("R11 irq masked", 16'(irq_o), 16'h0);
      wr(5'h0C, 16'h2000);  chk("R11 irq enabled", 16'(irq_o), 16'h1);
      // R8 second expiry
      idle(40);
      rd_is(5'h06, 16'h0006, "R8 second and boot flags");
      chk("R8 reset request", 16'(sys_rst_req_o), 16'h1);
      // R10 suppression
      wr(5'h0C, 16'h2010);  chk("R10 suppressed", 16'(sys_rst_req_o), 16'h0);
      rd_is(5'h0C, 16'h2010, "R10 cfg readback");
      wr(5'h0C, 16'h2000);  chk("R10 released", 16'(sys_rst_req_o), 16'h1);
      // R9 write-1-to-clear, timer halted first
      wr(5'h08, 16'h0800);
      wr(5'h06, 16'h0000);  rd_is(5'h06, 16'h0006, "R9 zero write no effect");
      wr(5'h06, 16'h0002);  rd_is(5'h06, 16'h0004, "R9 clear second only");
      chk("R9 reset request drops", 16'(sys_rst_req_o), 16'h0);
      wr(5'h06, 16'h0004);  rd_is(5'h06, 16'h0000, "R9 clear boot");
      wr(5'h04, 16'h0008);  rd_is(5'h04, 16'h0000, "R9 clear first");
      chk("R11 irq drops", 16'(irq_o), 16'h0);
      // R8 restart of the two-stage sequence
      wr(5'h08, 16'h0000);
      wr(5'h00, 16'h0001);
      idle(18);
      rd_is(5'h04, 16'h0008, "R8 restart first stage");
      rd_is(5'h06, 16'h0000, "R8 restart no second stage");
      // halted count stays unchanged
      wr(5'h08, 16'h0800);
      bus_addr = 5'h00; #1; held = bus_rdata;
      idle(12);             rd_is(5'h00, held, "R6 frozen after halt");
      // random phase
      for (int i = 0; i < 1500; i++) begin
         logic [15:0] d;
         d = 16'($urandom);
         case ($urandom_range(0, 9))
            0, 1: wr(5'h00, d);
            2:    wr(5'h04, d);
            3:    wr(5'h06, d);
            4: begin d[11] = ($urandom_range(0, 3) == 0); wr(5'h08, d); end
            5:    wr(5'h0C, d);
            6: begin
               if ($urandom_range(0, 1) == 1) d[9:0] = 10'($urandom_range(0, 7));
               wr(5'h12, d);
            end
            default: idle($urandom_range(0, 20));
         endcase
         case ($urandom_range(0, 6))
            0: rd_model(5'h00, "R2 R3 random count");
            1: rd_model(5'h04, "R7 R9 random sts1");
            2: rd_model(5'h06, "R8 R9 random sts2");
            3: rd_model(5'h08, "R6 random ctrl");
            4: rd_model(5'h0C, "R10 random cfg");
            5: rd_model(5'h12, "R4 R5 random init");
            default: rd_model(5'h02, "R3 random unmapped");
         endcase
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule